// File: doc/BRIEF.md
# Interprocessor Flag and Interrupt Unit

This block carries doorbell-style signals in one direction between two processors. The sending processor writes ones into a set view to raise pending bits in a flag vector. It reads that vector back through its own flag view, and it can drop bits itself through a clear view, for example after a timeout or when it needs no reply. The receiving processor sees the same vector through a status view. It acknowledges bits by writing ones into an acknowledge view. Two instances, one per direction, give full two-way signalling.

The lowest `IRQ_N` bits of the vector are also interrupt bits. Setting one of them sends a one-cycle pulse on a dedicated line toward the receiver's interrupt controller. The pulse is produced by the set write alone. A later clear or acknowledge of the flag has no way to recall an interrupt that has already gone out. All other bits are plain polled flags.

Top module: `ipfi_unit`

## Requirements
- R1: Out of reset every flag bit is 0 and no interrupt line is high.
- R2: A write to the sender set view (sender address 0) with a 1 in bit b, where b < IRQ_N (IRQ_N = 4), sets flag b. It also drives interrupt line b high for exactly the cycle that follows the write.
- R3: A 1 written to the set view in a bit at or above IRQ_N sets that flag and raises no interrupt.
- R4: The sender flag view (sender address 2) returns the pending vector, and the receiver status view (receiver address 0) always returns the same value.
- R5: A 1 written to the receiver acknowledge view (receiver address 1) clears that flag bit, as seen in both the flag view and the status view.
- R6: A 1 written to the sender clear view (sender address 1) clears that flag bit in both views.
- R7: An acknowledge or clear of a flag bit has no effect on an interrupt pulse that has already started.
- R8: Zero bits written to the set, clear or acknowledge views change nothing. Writes to the flag view, the status view or the unused sender address 3 are ignored.
- R9: The set view, the clear view and sender address 3 read as zero, and so does the acknowledge view.
- R10: When a set and an acknowledge hit the same bit in the same cycle, the set wins and the bit stays pending.
- R11: No interrupt line is high in a cycle that does not directly follow a set-view write with a 1 in that line's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_we | input | 1 | Sender write strobe |
| snd_addr | input | 2 | Sender view select: 0 set, 1 clear, 2 flag, 3 unused |
| snd_wdata | input | FLAG_W | Sender write data |
| snd_rdata | output | FLAG_W | Sender read data for the selected view |
| rcv_we | input | 1 | Receiver write strobe |
| rcv_addr | input | 1 | Receiver view select: 0 status, 1 acknowledge |
| rcv_wdata | input | FLAG_W | Receiver write data |
| rcv_rdata | output | FLAG_W | Receiver read data for the selected view |
| irq | output | IRQ_N | Interrupt pulses toward the receiver |

## Verification
A write takes effect at the clock edge that samples it. The flag and status views show the new vector one cycle later, and so does the interrupt pulse. The pulse lasts exactly that one cycle and is gone after the next edge. The bench drives inputs on the falling edge. It lets one rising edge pass, returns the ports to idle at the next falling edge, and reads the views and interrupt lines a nanosecond later. For pulse width, it steps one more rising edge and samples again off the edge.

// File: rtl/ipfi_pkg.sv
package ipfi_pkg;
   typedef enum logic [1:0] {
      SND_SET  = 2'd0,
      SND_CLR  = 2'd1,
      SND_FLAG = 2'd2,
      SND_RSVD = 2'd3
   } snd_view_e;

   typedef enum logic {
      RCV_STATUS = 1'b0,
      RCV_ACK    = 1'b1
   } rcv_view_e;
endpackage

// File: rtl/ipfi_sender_port.sv
module ipfi_sender_port
   import ipfi_pkg::*;
#(
   parameter int FLAG_W = 32
) (
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [FLAG_W-1:0] wdata,
   input  logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] set_mask,
   output logic [FLAG_W-1:0] clr_mask,
   output logic [FLAG_W-1:0] rdata
);
   snd_view_e view;
   assign view = snd_view_e'(addr);

   always_comb begin
      set_mask = '0;
      clr_mask = '0;
      if (we) begin
         unique case (view)
            SND_SET: set_mask = wdata;
            SND_CLR: clr_mask = wdata;
            default: ;
         endcase
      end
   end

   // only the flag view returns state; write-one views read as zero
   assign rdata = (view == SND_FLAG) ? flags : '0;
endmodule

// File: rtl/ipfi_receiver_port.sv
module ipfi_receiver_port
   import ipfi_pkg::*;
#(
   parameter int FLAG_W = 32
) (
   input  logic              we,
   input  logic              addr,
   input  logic [FLAG_W-1:0] wdata,
   input  logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] ack_mask,
   output logic [FLAG_W-1:0] rdata
);
   rcv_view_e view;
   assign view     = rcv_view_e'(addr);
   assign ack_mask = (we && view == RCV_ACK) ? wdata : '0;
   assign rdata    = (view == RCV_STATUS) ? flags : '0;
endmodule

// File: rtl/ipfi_flag_bank.sv
module ipfi_flag_bank #(
   parameter int FLAG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_mask,
   input  logic [FLAG_W-1:0] clr_mask,
   input  logic [FLAG_W-1:0] ack_mask,
   output logic [FLAG_W-1:0] flags
);
   for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      logic pend_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q <= 1'b0;
         else if (set_mask[b])
            pend_q <= 1'b1;            // set has priority over any drop
         else if (clr_mask[b] || ack_mask[b])
            pend_q <= 1'b0;
      end
      assign flags[b] = pend_q;
   end
endmodule

// File: rtl/ipfi_irq_gen.sv
module ipfi_irq_gen #(
   parameter int IRQ_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_N-1:0] trig,
   output logic [IRQ_N-1:0] irq
);
   // pulses depend on set writes only, so drops never touch them
   for (genvar i = 0; i < IRQ_N; i++) begin : g_line
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= trig[i];
      end
      assign irq[i] = pulse_q;
   end
endmodule

// File: rtl/ipfi_unit.sv
module ipfi_unit #(
   parameter int FLAG_W = 32,
   parameter int IRQ_N  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snd_we,
   input  logic [1:0]        snd_addr,
   input  logic [FLAG_W-1:0] snd_wdata,
   output logic [FLAG_W-1:0] snd_rdata,
   input  logic              rcv_we,
   input  logic              rcv_addr,
   input  logic [FLAG_W-1:0] rcv_wdata,
   output logic [FLAG_W-1:0] rcv_rdata,
   output logic [IRQ_N-1:0]  irq
);
   localparam int POLL_W = FLAG_W - IRQ_N;

   if (IRQ_N < 1 || IRQ_N > FLAG_W) begin : g_bad_irq_n
      $error("ipfi_unit: IRQ_N must lie in 1..FLAG_W");
   end
   if (POLL_W < 0) begin : g_bad_poll_w
      $error("ipfi_unit: negative polled-flag width");
   end

   logic [FLAG_W-1:0] set_mask;
   logic [FLAG_W-1:0] clr_mask;
   logic [FLAG_W-1:0] ack_mask;
   logic [FLAG_W-1:0] flags_q;

   ipfi_sender_port #(.FLAG_W(FLAG_W)) u_snd (
      .we(snd_we), .addr(snd_addr), .wdata(snd_wdata), .flags(flags_q),
      .set_mask(set_mask), .clr_mask(clr_mask), .rdata(snd_rdata)
   );

   ipfi_receiver_port #(.FLAG_W(FLAG_W)) u_rcv (
      .we(rcv_we), .addr(rcv_addr), .wdata(rcv_wdata), .flags(flags_q),
      .ack_mask(ack_mask), .rdata(rcv_rdata)
   );

   ipfi_flag_bank #(.FLAG_W(FLAG_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
      .ack_mask(ack_mask), .flags(flags_q)
   );

   ipfi_irq_gen #(.IRQ_N(IRQ_N)) u_irq (
      .clk(clk), .rst_n(rst_n), .trig(set_mask[IRQ_N-1:0]), .irq(irq)
   );
endmodule

// File: rtl/ipfi_unit_chk.sv
module ipfi_unit_chk #(
   parameter int FLAG_W = 32,
   parameter int IRQ_N  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              snd_we,
   input logic [1:0]        snd_addr,
   input logic [FLAG_W-1:0] snd_wdata,
   input logic [FLAG_W-1:0] snd_rdata,
   input logic              rcv_we,
   input logic              rcv_addr,
   input logic [FLAG_W-1:0] rcv_wdata,
   input logic [FLAG_W-1:0] rcv_rdata,
   input logic [IRQ_N-1:0]  irq,
   input logic [FLAG_W-1:0] flag_state
);
   logic set_wr;
   assign set_wr = snd_we && (snd_addr == 2'd0);

   assert_irq_follows_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> (irq == $past(snd_wdata[IRQ_N-1:0])));

   assert_irq_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !set_wr |=> (irq == '0));

   assert_status_mirrors_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_addr == 2'd2 && !rcv_addr) |-> (snd_rdata == rcv_rdata));

   assert_write_views_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_addr != 2'd2) |-> (snd_rdata == '0));

   assert_set_beats_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> ((flag_state & $past(snd_wdata)) == $past(snd_wdata)));

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_we && rcv_addr && !set_wr) |=> ((flag_state & $past(rcv_wdata)) == '0));
endmodule

bind ipfi_unit ipfi_unit_chk #(.FLAG_W(FLAG_W), .IRQ_N(IRQ_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_addr(snd_addr),
   .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .rcv_we(rcv_we),
   .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
   .irq(irq), .flag_state(flags_q)
);

// File: tb/tb_ipfi_unit.sv
`timescale 1ns/1ps
module tb_ipfi_unit;
   localparam int W = 32;
   localparam int N = 4;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          snd_we = 1'b0;
   logic [1:0]    snd_addr = 2'd2;
   logic [W-1:0]  snd_wdata = '0;
   logic [W-1:0]  snd_rdata;
   logic          rcv_we = 1'b0;
   logic          rcv_addr = 1'b0;
   logic [W-1:0]  rcv_wdata = '0;
   logic [W-1:0]  rcv_rdata;
   logic [N-1:0]  irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   ipfi_unit #(.FLAG_W(W), .IRQ_N(N)) dut (
      .clk(clk), .rst_n(rst_n), .snd_we(snd_we), .snd_addr(snd_addr),
      .snd_wdata(snd_wdata), .snd_rdata(snd_rdata), .rcv_we(rcv_we),
      .rcv_addr(rcv_addr), .rcv_wdata(rcv_wdata), .rcv_rdata(rcv_rdata),
      .irq(irq)
   );

   // {snd_we, snd_addr, snd_data, ack_we, ack_data, exp_flags, exp_irq}
   localparam logic [103:0] VECS [NV] = '{
      {1'b1, 2'd0, 32'h0000_0005, 1'b0, 32'h0,          32'h0000_0005, 4'h5}, // R2
      {1'b1, 2'd0, 32'h0001_0000, 1'b0, 32'h0,          32'h0001_0005, 4'h0}, // R3
      {1'b1, 2'd1, 32'h0000_0001, 1'b0, 32'h0,          32'h0001_0004, 4'h0}, // R6
      {1'b0, 2'd2, 32'h0,         1'b1, 32'h0001_0000,  32'h0000_0004, 4'h0}, // R5
      {1'b1, 2'd0, 32'h8000_0008, 1'b1, 32'h8000_0004,  32'h8000_0008, 4'h8}, // R10
      {1'b1, 2'd1, 32'h0,         1'b0, 32'h0,          32'h8000_0008, 4'h0}, // R8
      {1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 32'h0,          32'h8000_0008, 4'h0}, // R8
      {1'b0, 2'd2, 32'h0,         1'b1, 32'hFFFF_FFFF,  32'h0000_0000, 4'h0}  // R5
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic go_idle();
      snd_we = 1'b0; snd_addr = 2'd2; snd_wdata = '0;
      rcv_we = 1'b0; rcv_addr = 1'b0; rcv_wdata = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      go_idle();
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R1 flags in reset", snd_rdata, '0);
      check("R1 irq in reset", {28'h0, irq}, '0);
      @(negedge clk) rst_n = 1'b1;
      step();
      check("R1 flags after reset", snd_rdata, '0);
      check("R1 irq after reset", {28'h0, irq}, '0);

      for (int i = 0; i < NV; i++) begin
         logic [103:0] v;
         v = VECS[i];
         @(negedge clk);
         snd_we = v[103]; snd_addr = v[102:101]; snd_wdata = v[100:69];
         rcv_we = v[68]; rcv_addr = v[68]; rcv_wdata = v[67:36];
         step();
         check($sformatf("vector %0d flag view R2 R3 R5 R6 R8 R10", i), snd_rdata, v[35:4]);
         check($sformatf("vector %0d R4 status view", i), rcv_rdata, v[35:4]);
         check($sformatf("vector %0d irq R2 R3", i), {28'h0, irq}, {28'h0, v[3:0]});
         if (i == 0) begin
            step();
            check("R11 pulse gone next cycle", {28'h0, irq}, '0);
         end
      end

      // R9: write-one views read zero
      snd_addr = 2'd0; #1 check("R9 set view reads zero", snd_rdata, '0);
      snd_addr = 2'd1; #1 check("R9 clear view reads zero", snd_rdata, '0);
      snd_addr = 2'd3; #1 check("R9 unused address reads zero", snd_rdata, '0);
      rcv_addr = 1'b1; #1 check("R9 ack view reads zero", rcv_rdata, '0);
      go_idle();

      // R7: acknowledge during a pulse leaves the pulse intact
      @(negedge clk);
      snd_we = 1'b1; snd_addr = 2'd0; snd_wdata = 32'h0000_0002;
      step();
      rcv_we = 1'b1; rcv_addr = 1'b1; rcv_wdata = 32'h0000_0002;
      #1 check("R7 pulse held during ack", {28'h0, irq}, 32'h2);
      step();
      check("R7 ack cleared flag", snd_rdata, '0);
      check("R11 pulse ended", {28'h0, irq}, '0);

      // R8: write to status view and unused sender address ignored
      @(negedge clk);
      snd_we = 1'b1; snd_addr = 2'd0; snd_wdata = 32'h0000_0100;
      step();
      @(negedge clk);
      snd_we = 1'b1; snd_addr = 2'd3; snd_wdata = 32'hFFFF_FFFF;
      rcv_we = 1'b1; rcv_addr = 1'b0; rcv_wdata = 32'hFFFF_FFFF;
      step();
      check("R8 ignored writes keep flags", snd_rdata, 32'h0000_0100);
      check("R8 ignored writes no irq", {28'h0, irq}, '0);

      // R6 with clear racing nothing: sender drop of bit 8
      @(negedge clk);
      snd_we = 1'b1; snd_addr = 2'd1; snd_wdata = 32'h0000_0100;
      step();
      check("R6 clear drops bit", rcv_rdata, '0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule